// File: doc/BRIEF.md
# Single-Cycle RV32I Integer Core

This block is a small integer processor that runs a word-access subset of the RV32I base instruction set. Every instruction completes in one clock. In that cycle the core fetches a 32-bit word through a combinational instruction port, decodes it, and reads two source registers from a 32-entry register file. It computes the result, and at the closing edge it updates the program counter, the destination register and, for a store, one data word. There are no pipeline stages, so nothing has to be forwarded or stalled.

Instruction memory and data memory sit outside the core. Both are expected to answer within the same cycle: the fetch word must be valid for the address that `imem_addr` presents, and the load word must be valid for the address on `dmem_addr`. The only memory instructions are the word load and the word store. Any opcode outside the supported set, and any supported opcode with an unsupported width or condition code, runs as an empty step that only moves the program counter forward by 4.

Top module: `rv32_core`

## Requirements
- R1: While `rst_n` is low, `imem_addr` is 0 and neither `dmem_we` nor `dmem_re` is asserted. After release, the word at address 0 is the first instruction to execute.
- R2: Register-register operations (opcode 0110011) write rd with ADD/SUB (funct3 000, bit 30 picks SUB), SLL (001), SLT (010), SLTU (011), XOR (100), SRL/SRA (101, bit 30 picks SRA), OR (110) and AND (111). Shifts use only bits 4:0 of rs2.
- R3: Immediate operations (opcode 0010011) use the same funct3 codes against a sign-extended 12-bit immediate in bits 31:20. SLLI, SRLI and SRAI take their shift amount from bits 24:20, and bit 30 picks SRAI. For ADDI, bit 30 is only part of the immediate.
- R4: Register x0 reads as zero, and any write to it is dropped.
- R5: LUI (0110111) writes the 20-bit field in bits 31:12, shifted left by 12. AUIPC (0010111) writes that value plus the address of the AUIPC instruction.
- R6: Conditional branches (1100011) with funct3 000 BEQ, 001 BNE, 100 BLT, 101 BGE, 110 BLTU and 111 BGEU move PC by the sign-extended B-format offset when taken, and to PC+4 otherwise. Backward offsets work. JAL (1101111) always moves PC by its J-format offset.
- R7: JAL and JALR (1100111, funct3 000) write PC+4 to rd. JALR jumps to rs1 plus the I-format immediate, with bit 0 of that sum forced to zero.
- R8: SW (0100011, funct3 010) presents rs1+S-immediate on `dmem_addr` and rs2 on `dmem_wdata`, and asserts `dmem_we` for that single cycle. LW (0000011, funct3 010) asserts `dmem_re` and writes `dmem_rdata` to rd. No other instruction asserts either strobe.
- R9: Any other opcode, a load or store whose funct3 is not 010, and a branch whose funct3 is 010 or 011 each change no register, make no data access, and advance PC by 4.
- R10: Out of reset, `imem_addr` equals the current PC and is always a multiple of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Byte address of the instruction being fetched (current PC) |
| imem_data | input | 32 | Instruction word at `imem_addr`, valid in the same cycle |
| dmem_addr | output | 32 | Byte address of the data access |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, one cycle per SW |
| dmem_re | output | 1 | Load strobe, one cycle per LW |
| dmem_rdata | input | 32 | Load data for `dmem_addr`, valid in the same cycle |

## Verification
The assertions assume that both memories respond combinationally. They also assume that the fetched word is never unknown while the core is out of reset, because the checker decodes the opcode of whatever word is present. The bench meets this with array-backed memories that are read by continuous assignment. Every unused instruction location holds a jump-to-self, and each program ends in such a loop, so the core never fetches from an unwritten location. Reset is held across several clock edges and released away from an edge. Data addresses in the test programs stay inside the modelled data array.

// File: rtl/rv32_pkg.sv
package rv32_pkg;

  localparam int XLEN = 32;

  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [2:0] F3_WORD    = 3'b010;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_SLL, ALU_SLT, ALU_SLTU,
    ALU_XOR, ALU_SRL, ALU_SRA, ALU_OR, ALU_AND, ALU_PASSB
  } alu_op_e;

  typedef enum logic [2:0] {IMM_I, IMM_S, IMM_B, IMM_U, IMM_J} imm_kind_e;
  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK} wb_sel_e;

  typedef struct packed {
    logic      rf_we;
    logic      src_a_pc;
    logic      src_b_imm;
    logic      mem_rd;
    logic      mem_wr;
    logic      is_branch;
    logic      is_jal;
    logic      is_jalr;
    alu_op_e   alu_op;
    imm_kind_e imm_kind;
    wb_sel_e   wb_sel;
  } ctrl_t;

  // Control word of an instruction that only advances PC.
  function automatic ctrl_t ctrl_idle();
    ctrl_t c;
    c.rf_we     = 1'b0;
    c.src_a_pc  = 1'b0;
    c.src_b_imm = 1'b0;
    c.mem_rd    = 1'b0;
    c.mem_wr    = 1'b0;
    c.is_branch = 1'b0;
    c.is_jal    = 1'b0;
    c.is_jalr   = 1'b0;
    c.alu_op    = ALU_ADD;
    c.imm_kind  = IMM_I;
    c.wb_sel    = WB_ALU;
    return c;
  endfunction

  // funct3 plus the alternate bit select the arithmetic operation.
  function automatic alu_op_e alu_select(input logic [2:0] f3, input logic alt);
    case (f3)
      3'b000:  return alt ? ALU_SUB : ALU_ADD;
      3'b001:  return ALU_SLL;
      3'b010:  return ALU_SLT;
      3'b011:  return ALU_SLTU;
      3'b100:  return ALU_XOR;
      3'b101:  return alt ? ALU_SRA : ALU_SRL;
      3'b110:  return ALU_OR;
      default: return ALU_AND;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] imm_expand(input imm_kind_e k, input logic [31:7] ins);
    case (k)
      IMM_I:   return {{20{ins[31]}}, ins[31:20]};
      IMM_S:   return {{20{ins[31]}}, ins[31:25], ins[11:7]};
      IMM_B:   return {{19{ins[31]}}, ins[31], ins[7], ins[30:25], ins[11:8], 1'b0};
      IMM_U:   return {ins[31:12], 12'b0};
      default: return {{11{ins[31]}}, ins[31], ins[19:12], ins[20], ins[30:21], 1'b0};
    endcase
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_op_e op,
                                                input logic [XLEN-1:0] a,
                                                input logic [XLEN-1:0] b);
    case (op)
      ALU_ADD:  return a + b;
      ALU_SUB:  return a - b;
      ALU_SLL:  return a << b[4:0];
      ALU_SLT:  return {{(XLEN-1){1'b0}}, $signed(a) < $signed(b)};
      ALU_SLTU: return {{(XLEN-1){1'b0}}, a < b};
      ALU_XOR:  return a ^ b;
      ALU_SRL:  return a >> b[4:0];
      ALU_SRA:  return $unsigned($signed(a) >>> b[4:0]);
      ALU_OR:   return a | b;
      ALU_AND:  return a & b;
      default:  return b;
    endcase
  endfunction

  function automatic logic branch_eval(input logic [2:0] f3,
                                       input logic [XLEN-1:0] a,
                                       input logic [XLEN-1:0] b);
    case (f3)
      3'b000:  return a == b;
      3'b001:  return a != b;
      3'b100:  return $signed(a) < $signed(b);
      3'b101:  return $signed(a) >= $signed(b);
      3'b110:  return a < b;
      3'b111:  return a >= b;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/rv32_decode.sv
module rv32_decode
  import rv32_pkg::*;
(
  input  logic [6:0] opc,
  input  logic [2:0] f3,
  input  logic       alt,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = ctrl_idle();
    case (opc)
      OPC_OP: begin
        ctrl.rf_we  = 1'b1;
        ctrl.alu_op = alu_select(f3, alt);
      end
      OPC_OPIMM: begin
        ctrl.rf_we     = 1'b1;
        ctrl.src_b_imm = 1'b1;
        ctrl.alu_op    = alu_select(f3, alt & (f3 == 3'b101));
      end
      OPC_LOAD: if (f3 == F3_WORD) begin
        ctrl.rf_we     = 1'b1;
        ctrl.src_b_imm = 1'b1;
        ctrl.mem_rd    = 1'b1;
        ctrl.wb_sel    = WB_MEM;
      end
      OPC_STORE: if (f3 == F3_WORD) begin
        ctrl.src_b_imm = 1'b1;
        ctrl.mem_wr    = 1'b1;
        ctrl.imm_kind  = IMM_S;
      end
      OPC_BRANCH: if (f3[2:1] != 2'b01) begin
        ctrl.is_branch = 1'b1;
        ctrl.imm_kind  = IMM_B;
      end
      OPC_JAL: begin
        ctrl.rf_we    = 1'b1;
        ctrl.is_jal   = 1'b1;
        ctrl.imm_kind = IMM_J;
        ctrl.wb_sel   = WB_LINK;
      end
      OPC_JALR: if (f3 == 3'b000) begin
        ctrl.rf_we     = 1'b1;
        ctrl.is_jalr   = 1'b1;
        ctrl.src_b_imm = 1'b1;
        ctrl.wb_sel    = WB_LINK;
      end
      OPC_LUI: begin
        ctrl.rf_we     = 1'b1;
        ctrl.src_b_imm = 1'b1;
        ctrl.imm_kind  = IMM_U;
        ctrl.alu_op    = ALU_PASSB;
      end
      OPC_AUIPC: begin
        ctrl.rf_we     = 1'b1;
        ctrl.src_a_pc  = 1'b1;
        ctrl.src_b_imm = 1'b1;
        ctrl.imm_kind  = IMM_U;
      end
      default: ctrl = ctrl_idle();
    endcase
  end

endmodule

// File: rtl/rv32_regfile.sv
module rv32_regfile #(
  parameter int NREG = 32,
  parameter int DW   = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [DW-1:0] rd1,
  output logic [DW-1:0] rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd
);

  // Entry 0 has no storage: it reads as zero and writes to it vanish.
  logic [DW-1:0] regs [1:NREG-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 1; i < NREG; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

endmodule

// File: rtl/rv32_alu.sv
module rv32_alu
  import rv32_pkg::*;
(
  input  alu_op_e          op,
  input  logic [2:0]       f3,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  output logic [XLEN-1:0]  res,
  output logic             cond
);

  assign res  = alu_eval(op, a, b);
  assign cond = branch_eval(f3, a, b);

endmodule

// File: rtl/rv32_core.sv
module rv32_core
  import rv32_pkg::*;
#(
  parameter int              NREG     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] imem_addr,
  input  logic [XLEN-1:0] imem_data,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  output logic            dmem_re,
  input  logic [XLEN-1:0] dmem_rdata
);

  localparam int RAW = $clog2(NREG);

  logic [XLEN-1:0] pc_q, pc_next, pc_seq, pc_rel;
  ctrl_t           ctrl;
  logic [RAW-1:0]  rs1_idx, rs2_idx, rd_idx;
  logic [XLEN-1:0] rs1_rdata, rs2_rdata, imm, op_a, op_b, alu_res;
  logic            br_cond, redirect;
  logic            rf_wr_en;
  logic [XLEN-1:0] rf_wr_data;

  assign rs1_idx = imem_data[15 +: RAW];
  assign rs2_idx = imem_data[20 +: RAW];
  assign rd_idx  = imem_data[7 +: RAW];

  rv32_decode u_dec (
    .opc  (imem_data[6:0]),
    .f3   (imem_data[14:12]),
    .alt  (imem_data[30]),
    .ctrl (ctrl)
  );

  rv32_regfile #(.NREG(NREG), .DW(XLEN)) u_rf (
    .clk (clk),
    .rst_n (rst_n),
    .ra1 (rs1_idx),
    .ra2 (rs2_idx),
    .rd1 (rs1_rdata),
    .rd2 (rs2_rdata),
    .we  (rf_wr_en),
    .wa  (rd_idx),
    .wd  (rf_wr_data)
  );

  assign imm  = imm_expand(ctrl.imm_kind, imem_data[31:7]);
  assign op_a = ctrl.src_a_pc  ? pc_q : rs1_rdata;
  assign op_b = ctrl.src_b_imm ? imm  : rs2_rdata;

  rv32_alu u_alu (
    .op   (ctrl.alu_op),
    .f3   (imem_data[14:12]),
    .a    (op_a),
    .b    (op_b),
    .res  (alu_res),
    .cond (br_cond)
  );

  // Next-PC selection: sequential, PC-relative, or register-indirect.
  assign pc_seq   = pc_q + XLEN'(4);
  assign pc_rel   = pc_q + imm;
  assign redirect = ctrl.is_jal | (ctrl.is_branch & br_cond);

  always_comb begin
    if (ctrl.is_jalr)   pc_next = {alu_res[XLEN-1:1], 1'b0};
    else if (redirect)  pc_next = pc_rel;
    else                pc_next = pc_seq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RESET_PC;
    else        pc_q <= pc_next;
  end

  // Write-back selection.
  assign rf_wr_en = ctrl.rf_we;
  always_comb begin
    case (ctrl.wb_sel)
      WB_MEM:  rf_wr_data = dmem_rdata;
      WB_LINK: rf_wr_data = pc_seq;
      default: rf_wr_data = alu_res;
    endcase
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = alu_res;
  assign dmem_wdata = rs2_rdata;
  assign dmem_we    = ctrl.mem_wr & rst_n;
  assign dmem_re    = ctrl.mem_rd & rst_n;

endmodule

// File: rtl/rv32_core_chk.sv
module rv32_core_chk
  import rv32_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input logic            clk,
  input logic            rst_n,
  input logic [XLEN-1:0] imem_addr,
  input logic [6:0]      opc,
  input logic [2:0]      f3,
  input logic [4:0]      rs1_idx,
  input logic [XLEN-1:0] rs1_rdata,
  input logic            rf_wr_en,
  input logic [XLEN-1:0] rf_wr_data,
  input logic            dmem_we,
  input logic            dmem_re
);

  logic flow_op, known_op;
  assign flow_op  = (opc == OPC_BRANCH) || (opc == OPC_JAL) || (opc == OPC_JALR);
  assign known_op = (opc == OPC_OP) || (opc == OPC_OPIMM) || (opc == OPC_LOAD) ||
                    (opc == OPC_STORE) || flow_op || (opc == OPC_LUI) || (opc == OPC_AUIPC);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (imem_addr == RESET_PC && !dmem_we && !dmem_re)
        else $error("core not quiet in reset");
    end
  end

  assert_fetch_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
    imem_addr[1:0] == 2'b00);

  assert_seq_pc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !flow_op |=> imem_addr == $past(imem_addr) + XLEN'(4));

  assert_x0_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rs1_idx == 5'd0 |-> rs1_rdata == '0);

  assert_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OPC_JAL || opc == OPC_JALR) |-> rf_wr_data == imem_addr + XLEN'(4));

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(dmem_we && dmem_re));

  assert_store_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OPC_STORE && f3 == F3_WORD) |-> dmem_we);

  assert_unknown_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !known_op |-> (!dmem_we && !dmem_re && !rf_wr_en));

endmodule

bind rv32_core rv32_core_chk #(.RESET_PC(RESET_PC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .imem_addr  (imem_addr),
  .opc        (imem_data[6:0]),
  .f3         (imem_data[14:12]),
  .rs1_idx    (imem_data[19:15]),
  .rs1_rdata  (rs1_rdata),
  .rf_wr_en   (rf_wr_en),
  .rf_wr_data (rf_wr_data),
  .dmem_we    (dmem_we),
  .dmem_re    (dmem_re)
);

// File: tb/rv32_core_tb.sv
module rv32_core_tb;

  localparam logic [31:0] SENT = 32'hCCCC_CCCC;
  localparam logic [31:0] LOOP = 32'h0000_006F;
  localparam int WATCHDOG = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, dmem_re;

  rv32_core u_dut (
    .clk (clk), .rst_n (rst_n),
    .imem_addr (imem_addr), .imem_data (imem_data),
    .dmem_addr (dmem_addr), .dmem_wdata (dmem_wdata),
    .dmem_we (dmem_we), .dmem_re (dmem_re), .dmem_rdata (dmem_rdata)
  );

  always #2 clk = ~clk;

  logic [31:0] imem [0:2047];
  logic [31:0] dmem [0:511];
  logic [31:0] want [0:511];
  string       sreq [0:511];
  int pc_idx = 0, slot = 0, n_stores = 0, n_loads = 0;
  int checks = 0, errors = 0;
  int we_cnt, re_cnt, bad_fetch;
  int end_pc = 0;
  bit done = 1'b0;

  assign imem_data  = imem[imem_addr[12:2]];
  assign dmem_rdata = dmem[dmem_addr[10:2]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) dmem[i] <= SENT;
      we_cnt <= 0; re_cnt <= 0; bad_fetch <= 0;
    end else begin
      if (dmem_we) begin
        dmem[dmem_addr[10:2]] <= dmem_wdata;
        we_cnt <= we_cnt + 1;
      end
      if (dmem_re) re_cnt <= re_cnt + 1;
      if (imem_addr[1:0] != 2'b00) bad_fetch <= bad_fetch + 1;
    end
  end

  // Encoders
  function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2,
      input logic [4:0] rs1, input logic [2:0] f3, input logic [4:0] rd);
    return {f7, rs2, rs1, f3, rd, 7'b0110011};
  endfunction
  function automatic logic [31:0] enc_i(input logic [11:0] im, input logic [4:0] rs1,
      input logic [2:0] f3, input logic [4:0] rd, input logic [6:0] op);
    return {im, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] enc_s(input logic [11:0] im, input logic [4:0] rs2,
      input logic [4:0] rs1, input logic [2:0] f3);
    return {im[11:5], rs2, rs1, f3, im[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] enc_b(input logic [12:0] im, input logic [4:0] rs2,
      input logic [4:0] rs1, input logic [2:0] f3);
    return {im[12], im[10:5], rs2, rs1, f3, im[4:1], im[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] enc_u(input logic [19:0] im, input logic [4:0] rd,
      input logic [6:0] op);
    return {im, rd, op};
  endfunction
  function automatic logic [31:0] enc_j(input logic [20:0] im, input logic [4:0] rd);
    return {im[20], im[10:1], im[11], im[19:12], rd, 7'b1101111};
  endfunction

  // Reference arithmetic, indexed 0..9 as ADD SUB SLL SLT SLTU XOR SRL SRA OR AND
  function automatic logic [31:0] ref_alu(input int k, input logic [31:0] a, input logic [31:0] b);
    int sh;
    sh = int'(b % 32);
    case (k)
      0: return a + b;
      1: return a + (~b + 32'd1);
      2: return a * (32'd1 << sh);
      3: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4: return (a < b) ? 32'd1 : 32'd0;
      5: return (a | b) & ~(a & b);
      6: return a / (32'd1 << sh);
      7: return a[31] ? ~((~a) / (32'd1 << sh)) : a / (32'd1 << sh);
      8: return a | b;
      default: return a & b;
    endcase
  endfunction

  function automatic bit ref_br(input logic [2:0] f3, input logic [31:0] a, input logic [31:0] b);
    case (f3)
      3'b000: return a == b;
      3'b001: return a != b;
      3'b100: return $signed(a) < $signed(b);
      3'b101: return !($signed(a) < $signed(b));
      3'b110: return a < b;
      default: return !(a < b);
    endcase
  endfunction

  task automatic emit(input logic [31:0] w);
    imem[pc_idx] = w;
    pc_idx++;
  endtask

  task automatic put_store(input logic [4:0] rs, input logic [31:0] v, input string r);
    emit(enc_s(12'(slot * 4), rs, 5'd0, 3'b010));
    want[slot] = v; sreq[slot] = r;
    slot++; n_stores++;
  endtask

  task automatic load_const(input logic [4:0] rd, input logic [31:0] v);
    logic [31:0] up;
    up = v + 32'h800;
    emit(enc_u(up[31:12], rd, 7'b0110111));
    emit(enc_i(v[11:0], rd, 3'b000, rd, 7'b0010011));
  endtask

  task automatic chk(input bit ok, input string r, input string what,
                     input logic [31:0] act, input logic [31:0] exv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exv);
    end
  endtask

  task automatic build();
    logic [31:0] pa [8];
    logic [31:0] pb [8];
    logic [2:0]  rf3 [10];
    logic [6:0]  rf7 [10];
    logic [2:0]  if3 [9];
    logic [6:0]  if7 [9];
    int          iref [9];
    logic [2:0]  bf3 [6];
    int base, tgt, s;
    for (int i = 0; i < 2048; i++) imem[i] = LOOP;
    pa = '{32'd0, 32'd5, 32'hFFFF_FFF9, 32'h8000_0000, 32'h7FFF_FFFF, 32'h1234_5678, 32'hDEAD_BEEF, 32'd9};
    pb = '{32'd0, 32'd3, 32'd3, 32'd1, 32'hFFFF_FFFF, 32'h0000_081F, 32'h0000_0024, 32'd9};
    rf3 = '{3'd0, 3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd5, 3'd6, 3'd7};
    rf7 = '{7'h00, 7'h20, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h20, 7'h00, 7'h00};
    // ADDI SLTI SLTIU XORI ORI ANDI SLLI SRLI SRAI
    if3 = '{3'd0, 3'd2, 3'd3, 3'd4, 3'd6, 3'd7, 3'd1, 3'd5, 3'd5};
    if7 = '{7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h20};
    iref = '{0, 3, 4, 5, 8, 9, 2, 6, 7};
    bf3 = '{3'd0, 3'd1, 3'd4, 3'd5, 3'd6, 3'd7};

    put_store(5'd0, 32'd0, "R1");  // first word: proves fetch starts at 0
    for (int p = 0; p < 8; p++) begin
      load_const(5'd1, pa[p]);
      load_const(5'd2, pb[p]);
      for (int k = 0; k < 10; k++) begin  // R2
        emit(enc_r(rf7[k], 5'd2, 5'd1, rf3[k], 5'd3));
        put_store(5'd3, ref_alu(k, pa[p], pb[p]), "R2");
      end
      for (int k = 0; k < 9; k++) begin   // R3
        logic [11:0] im;
        logic [31:0] opv;
        if (k >= 6) begin
          im  = {if7[k], pb[p][4:0]};
          opv = {27'd0, pb[p][4:0]};
        end else begin
          im  = pb[p][11:0];
          opv = {{20{pb[p][11]}}, pb[p][11:0]};
        end
        emit(enc_i(im, 5'd1, if3[k], 5'd3, 7'b0010011));
        put_store(5'd3, ref_alu(iref[k], pa[p], opv), "R3");
      end
      for (int k = 0; k < 6; k++) begin   // R6
        emit(enc_i(12'd1, 5'd0, 3'd0, 5'd10, 7'b0010011));
        emit(enc_b(13'd8, 5'd2, 5'd1, bf3[k]));
        emit(enc_i(12'd2, 5'd0, 3'd0, 5'd10, 7'b0010011));
        put_store(5'd10, ref_br(bf3[k], pa[p], pb[p]) ? 32'd1 : 32'd2, "R6");
      end
    end
    // R6 backward branch loop: 3 iterations of +5
    emit(enc_i(12'd3, 5'd0, 3'd0, 5'd13, 7'b0010011));
    emit(enc_i(12'd0, 5'd0, 3'd0, 5'd14, 7'b0010011));
    emit(enc_i(12'd5, 5'd14, 3'd0, 5'd14, 7'b0010011));
    emit(enc_i(12'hFFF, 5'd13, 3'd0, 5'd13, 7'b0010011));
    emit(enc_b(13'h1FF8, 5'd0, 5'd13, 3'b001));
    put_store(5'd14, 32'd15, "R6");
    // R6 JAL skips one instruction
    emit(enc_i(12'd1, 5'd0, 3'd0, 5'd18, 7'b0010011));
    emit(enc_j(21'd8, 5'd0));
    emit(enc_i(12'd2, 5'd0, 3'd0, 5'd18, 7'b0010011));
    put_store(5'd18, 32'd1, "R6");
    // R7 JAL link value
    base = pc_idx * 4;
    emit(enc_j(21'd8, 5'd5));
    emit(enc_i(12'd0, 5'd0, 3'd0, 5'd5, 7'b0010011));
    put_store(5'd5, 32'(base + 4), "R7");
    // R7 JALR: rs1+imm is odd, bit 0 must be cleared
    base = pc_idx * 4;
    tgt  = base + 20;
    emit(enc_i(12'd4, 5'd0, 3'd0, 5'd19, 7'b0010011));
    load_const(5'd6, 32'(tgt - 7));
    emit(enc_i(12'd8, 5'd6, 3'd0, 5'd7, 7'b1100111));
    emit(enc_i(12'd9, 5'd0, 3'd0, 5'd19, 7'b0010011));
    put_store(5'd19, 32'd4, "R7");
    put_store(5'd7, 32'(base + 16), "R7");
    // R4 writes to x0 vanish
    emit(enc_i(12'd77, 5'd0, 3'd0, 5'd0, 7'b0010011));
    put_store(5'd0, 32'd0, "R4");
    emit(enc_r(7'h00, 5'd1, 5'd1, 3'd0, 5'd0));
    put_store(5'd0, 32'd0, "R4");
    // R5 LUI / AUIPC
    emit(enc_u(20'hABCDE, 5'd16, 7'b0110111));
    put_store(5'd16, 32'hABCD_E000, "R5");
    base = pc_idx * 4;
    emit(enc_u(20'h00012, 5'd17, 7'b0010111));
    put_store(5'd17, 32'(base) + 32'h0001_2000, "R5");
    base = pc_idx * 4;
    emit(enc_u(20'hFFFFF, 5'd17, 7'b0010111));
    put_store(5'd17, 32'(base) + 32'hFFFF_F000, "R5");
    // R8 store then load back, zero base and offset base
    load_const(5'd20, 32'h5A5A_F00D);
    s = slot;
    put_store(5'd20, 32'h5A5A_F00D, "R8");
    emit(enc_i(12'(s * 4), 5'd0, 3'b010, 5'd21, 7'b0000011)); n_loads++;
    put_store(5'd21, 32'h5A5A_F00D, "R8");
    load_const(5'd22, 32'(s * 4 + 100));
    emit(enc_i(12'hF9C, 5'd22, 3'b010, 5'd23, 7'b0000011)); n_loads++;
    put_store(5'd23, 32'h5A5A_F00D, "R8");
    // R9 unsupported encodings leave x11 alone
    emit(enc_i(12'd7, 5'd0, 3'd0, 5'd11, 7'b0010011));
    emit(32'h0000_05F3);
    emit(32'h0000_058F);
    emit(enc_i(12'd0, 5'd0, 3'b000, 5'd11, 7'b0000011));
    emit(32'h0000_05FF);
    put_store(5'd11, 32'd7, "R9");
    // R9 byte store writes nothing
    emit(enc_s(12'(slot * 4), 5'd20, 5'd0, 3'b000));
    want[slot] = SENT; sreq[slot] = "R9"; slot++;
    // R9 branch with funct3 010 never redirects
    emit(enc_i(12'd1, 5'd0, 3'd0, 5'd24, 7'b0010011));
    emit(enc_b(13'd8, 5'd0, 5'd0, 3'b010));
    emit(enc_i(12'd2, 5'd0, 3'd0, 5'd24, 7'b0010011));
    put_store(5'd24, 32'd2, "R9");
    end_pc = pc_idx * 4;
    emit(LOOP);
  endtask

  initial begin
    build();
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(imem_addr == 32'd0, "R1", "fetch address in reset", imem_addr, 32'd0);
    chk(!dmem_we && !dmem_re, "R1", "data strobes in reset", {30'd0, dmem_we, dmem_re}, 32'd0);
    rst_n = 1'b1;
    repeat (pc_idx + 40) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < slot; i++)
      chk(dmem[i] === want[i], sreq[i], $sformatf("data word %0d", i), dmem[i], want[i]);
    chk(we_cnt == n_stores, "R8", "store strobe count", 32'(we_cnt), 32'(n_stores));
    chk(re_cnt == n_loads, "R8", "load strobe count", 32'(re_cnt), 32'(n_loads));
    chk(imem_addr == 32'(end_pc), "R10", "final fetch address", imem_addr, 32'(end_pc));
    chk(bad_fetch == 0, "R10", "misaligned fetch cycles", 32'(bad_fetch), 32'd0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=<%0d", WATCHDOG, WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule